// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block listens to an open-drain two-wire serial bus made of a data line and a clock line, and drives nothing onto it. Each raw line level enters through its own chain of synchronizer flops. Edges are then judged on the synchronized copies, so the order of data-line and clock-line transitions is decided inside one clock domain.

It reports three kinds of bus condition as one-cycle pulses: a first START, a repeated START and a STOP. It also holds a busy level that arbitration logic in a multi-master system can check before it tries to begin a transfer.

Inside a frame, the block counts bits on each rising clock-line edge. It captures the first byte after every START or repeated START, and splits it into a 7-bit target address and a direction bit. It also reports the acknowledge slot that follows each byte.

Top module: `tw_cond_mon`

## Requirements
- R1: While reset is high, and on the first cycle after it, `start_o`, `rstart_o`, `stop_o`, `addr_valid_o` and `ack_valid_o` are 0, `busy_o` is 0 and `bit_idx_o` is 0.
- R2: A falling data line while the clock line stays high, with the bus free, gives a one-cycle `start_o` pulse and sets `busy_o`. The pulse appears on the third rising edge of `clk` after the input change. This count is two synchronizer stages plus one output register.
- R3: A rising data line while the clock line stays high gives a one-cycle `stop_o` pulse. `busy_o` is 0 from that same cycle on.
- R4: A START condition while `busy_o` is 1 gives `rstart_o` and never `start_o`. `busy_o` stays 1 through it.
- R5: No condition pulse is produced until both lines have been seen high together at least once after reset. A data-line rise with the clock line high that is itself the first moment both lines are high gives no `stop_o`.
- R6: Data bits are sampled on each rising clock-line edge, most significant bit first. Data-line changes while the clock line is low produce no condition pulse.
- R7: Only for the first byte after a START or repeated START, `addr_valid_o` pulses for one cycle after the eighth bit. At that point `addr_o` holds the first seven bits received, in order from bit 7 down to bit 1. `rw_o` holds the eighth bit, which is bit 0, with 1 meaning read. Later bytes give no `addr_valid_o`.
- R8: On the ninth rising clock-line edge of every byte, `ack_valid_o` pulses for one cycle. `ack_o` takes the sampled data line, where 0 means acknowledged and 1 means not acknowledged.
- R9: `bit_idx_o` gives the number of bits of the current byte received so far, from 0 to 8. It returns to 0 on every START, repeated START, STOP and after each acknowledge slot.
- R10: `start_o`, `rstart_o` and `stop_o` each last exactly one cycle, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Raw data-line level |
| scl_in | input | 1 | Raw clock-line level |
| start_o | output | 1 | One-cycle pulse on a START seen with the bus free |
| rstart_o | output | 1 | One-cycle pulse on a START seen while busy |
| stop_o | output | 1 | One-cycle pulse on a STOP |
| busy_o | output | 1 | Bus owned, from START until STOP |
| addr_valid_o | output | 1 | One-cycle strobe: address byte complete |
| addr_o | output | 7 | Captured target address |
| rw_o | output | 1 | Captured direction bit, 1 = read |
| ack_valid_o | output | 1 | One-cycle strobe: acknowledge slot sampled |
| ack_o | output | 1 | Sampled acknowledge, 0 = ACK |
| bit_idx_o | output | 4 | Bits received in the current byte |

## Verification
The bench first raises the data line with the clock line high straight out of reset. A monitor with no arming step would report a STOP that never happened there.

It then issues a repeated START in the middle of a data byte. A design that does not consult busy would emit a second plain START. A design that does not clear its bit counter would mis-frame the following address byte, so the bench checks both the address and the direction bit.

A second byte after the address byte must give no address strobe, which catches a first-byte flag that is never cleared. An exact-cycle check on the START pulse catches a missing or extra synchronizer stage.

// File: rtl/tw_mon_pkg.sv
package tw_mon_pkg;

  // Line events seen on the synchronized bus, valid for one clock.
  typedef struct packed {
    logic start;   // data fell while clock high
    logic stop;    // data rose while clock high
    logic rise;    // clock line rose
  } tw_evt_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 1) begin : g_one
      logic r;
      always_ff @(posedge clk) begin
        if (rst) r <= 1'b0;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect
  import tw_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sda_s,
  input  logic    scl_s,
  output tw_evt_t evt_o,
  output logic    start_o,
  output logic    rstart_o,
  output logic    stop_o,
  output logic    busy_o
);

  logic prev_sda, prev_scl;
  logic armed;
  tw_evt_t evt;

  // Conditions need the clock line high on both sides of the data edge.
  always_comb begin
    evt.start = armed & prev_scl & scl_s & prev_sda & ~sda_s;
    evt.stop  = armed & prev_scl & scl_s & ~prev_sda & sda_s;
    evt.rise  = ~prev_scl & scl_s;
  end
  assign evt_o = evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sda <= 1'b0;
      prev_scl <= 1'b0;
      armed    <= 1'b0;
      start_o  <= 1'b0;
      rstart_o <= 1'b0;
      stop_o   <= 1'b0;
      busy_o   <= 1'b0;
    end else begin
      prev_sda <= sda_s;
      prev_scl <= scl_s;
      if (sda_s && scl_s) armed <= 1'b1;
      start_o  <= evt.start & ~busy_o;
      rstart_o <= evt.start & busy_o;
      stop_o   <= evt.stop;
      if (evt.start)     busy_o <= 1'b1;
      else if (evt.stop) busy_o <= 1'b0;
    end
  end

endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_mon_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  tw_evt_t           evt,
  input  logic              sda_s,
  output logic              addr_valid_o,
  output logic [BYTE_W-2:0] addr_o,
  output logic              rw_o,
  output logic              ack_valid_o,
  output logic              ack_o,
  output logic [IDX_W-1:0]  bit_idx_o
);

  localparam logic [IDX_W-1:0] FULL = IDX_W'(BYTE_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTE_W - 1);

  logic              in_frame;
  logic              first_byte;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] nxt;

  assign nxt = {shreg[BYTE_W-2:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame     <= 1'b0;
      first_byte   <= 1'b0;
      shreg        <= '0;
      bit_idx_o    <= '0;
      addr_valid_o <= 1'b0;
      addr_o       <= '0;
      rw_o         <= 1'b0;
      ack_valid_o  <= 1'b0;
      ack_o        <= 1'b1;
    end else begin
      addr_valid_o <= 1'b0;
      ack_valid_o  <= 1'b0;
      if (evt.start) begin
        in_frame   <= 1'b1;
        first_byte <= 1'b1;
        bit_idx_o  <= '0;
      end else if (evt.stop) begin
        in_frame   <= 1'b0;
        first_byte <= 1'b0;
        bit_idx_o  <= '0;
      end else if (evt.rise && in_frame) begin
        if (bit_idx_o == FULL) begin
          ack_valid_o <= 1'b1;
          ack_o       <= sda_s;
          bit_idx_o   <= '0;
          first_byte  <= 1'b0;
        end else begin
          shreg     <= nxt;
          bit_idx_o <= bit_idx_o + 1'b1;
          if (first_byte && bit_idx_o == LAST) begin
            addr_valid_o <= 1'b1;
            addr_o       <= nxt[BYTE_W-1:1];
            rw_o         <= nxt[0];
          end
        end
      end
    end
  end

endmodule

// File: rtl/tw_cond_mon.sv
module tw_cond_mon
  import tw_mon_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              start_o,
  output logic              rstart_o,
  output logic              stop_o,
  output logic              busy_o,
  output logic              addr_valid_o,
  output logic [BYTE_W-2:0] addr_o,
  output logic              rw_o,
  output logic              ack_valid_o,
  output logic              ack_o,
  output logic [IDX_W-1:0]  bit_idx_o
);

  logic    sda_s, scl_s;
  tw_evt_t evt;

  tw_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst(rst), .d(sda_in), .q(sda_s)
  );

  tw_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst(rst), .d(scl_in), .q(scl_s)
  );

  tw_cond_detect u_cond (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_s(scl_s), .evt_o(evt),
    .start_o(start_o), .rstart_o(rstart_o), .stop_o(stop_o), .busy_o(busy_o)
  );

  tw_frame #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_frame (
    .clk(clk), .rst(rst), .evt(evt), .sda_s(sda_s),
    .addr_valid_o(addr_valid_o), .addr_o(addr_o), .rw_o(rw_o),
    .ack_valid_o(ack_valid_o), .ack_o(ack_o), .bit_idx_o(bit_idx_o)
  );

endmodule

// File: rtl/tw_cond_mon_chk.sv
module tw_cond_mon_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_o,
  input logic       rstart_o,
  input logic       stop_o,
  input logic       busy_o,
  input logic       addr_valid_o,
  input logic       ack_valid_o,
  input logic [3:0] bit_idx_o
);

  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> start_o);

  assert_start_free_R2: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (busy_o && !$past(busy_o)));

  assert_busy_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> stop_o);

  assert_stop_clear_R3: assert property (@(posedge clk) disable iff (rst)
    stop_o |-> !busy_o);

  assert_rstart_held_R4: assert property (@(posedge clk) disable iff (rst)
    rstart_o |-> (busy_o && $past(busy_o)));

  assert_addr_slot_R7: assert property (@(posedge clk) disable iff (rst)
    addr_valid_o |-> (bit_idx_o == 4'd8));

  assert_ack_slot_R8: assert property (@(posedge clk) disable iff (rst)
    ack_valid_o |-> (bit_idx_o == 4'd0 && !addr_valid_o));

  assert_idx_range_R9: assert property (@(posedge clk) disable iff (rst)
    bit_idx_o <= 4'd8);

  assert_idx_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (start_o || rstart_o || stop_o) |-> (bit_idx_o == 4'd0));

  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_o, rstart_o, stop_o}));

  assert_start_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  assert_stop_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> !stop_o);

endmodule

bind tw_cond_mon tw_cond_mon_chk u_chk (
  .clk(clk), .rst(rst), .start_o(start_o), .rstart_o(rstart_o),
  .stop_o(stop_o), .busy_o(busy_o), .addr_valid_o(addr_valid_o),
  .ack_valid_o(ack_valid_o), .bit_idx_o(bit_idx_o)
);

// File: tb/tw_cond_mon_tb.sv
`timescale 1ns/1ps
module tw_cond_mon_tb;

  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sda_i = 1'b0;
  logic scl_i = 1'b0;
  logic start_o, rstart_o, stop_o, busy_o, addr_valid_o, rw_o;
  logic ack_valid_o, ack_o;
  logic [6:0] addr_o;
  logic [3:0] bit_idx_o;

  always #5 clk = ~clk;

  tw_cond_mon u_dut (
    .clk(clk), .rst(rst), .sda_in(sda_i), .scl_in(scl_i),
    .start_o(start_o), .rstart_o(rstart_o), .stop_o(stop_o), .busy_o(busy_o),
    .addr_valid_o(addr_valid_o), .addr_o(addr_o), .rw_o(rw_o),
    .ack_valid_o(ack_valid_o), .ack_o(ack_o), .bit_idx_o(bit_idx_o)
  );

  int n_chk = 0, n_bad = 0;
  int c_start = 0, c_rstart = 0, c_stop = 0, c_addr = 0, c_ack = 0;
  logic [6:0] l_addr = '0;
  logic l_rw = 1'b0, l_ack = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (start_o)  c_start++;
      if (rstart_o) c_rstart++;
      if (stop_o)   c_stop++;
      if (addr_valid_o) begin c_addr++; l_addr = addr_o; l_rw = rw_o; end
      if (ack_valid_o)  begin c_ack++;  l_ack = ack_o; end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic phase(input logic d, input logic c);
    @(negedge clk);
    sda_i = d;
    scl_i = c;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic send_start();  phase(1,1); phase(0,1); phase(0,0); endtask
  task automatic send_rstart(); phase(1,0); phase(1,1); phase(0,1); phase(0,0); endtask
  task automatic send_stop();   phase(0,0); phase(0,1); phase(1,1); endtask
  task automatic send_bit(input logic b); phase(b,0); phase(b,1); phase(b,0); endtask
  task automatic send_byte(input logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    send_bit(ack);
  endtask

  // R1: outputs at and just after reset
  task automatic t_reset();
    @(negedge clk);
    check("R1 start",  start_o,  0);
    check("R1 busy",   busy_o,   0);
    check("R1 bit_idx", bit_idx_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pulses", {start_o, rstart_o, stop_o, addr_valid_o, ack_valid_o}, 0);
    check("R1 busy after release", busy_o, 0);
  endtask

  // R5: first data rise with clock high must not report STOP
  task automatic t_arming();
    phase(0,1);
    phase(1,1);
    settle();
    check("R5 no stop before armed", c_stop, 0);
    check("R5 no start", c_start, 0);
    check("R5 busy", busy_o, 0);
  endtask

  // R2: exact pulse cycle and busy
  task automatic t_start_latency();
    @(negedge clk);
    sda_i = 1'b0;
    @(negedge clk); check("R2 edge1", start_o, 0);
    @(negedge clk); check("R2 edge2", start_o, 0);
    @(negedge clk); check("R2 edge3 pulse", start_o, 1);
    check("R2 busy set", busy_o, 1);
    @(negedge clk); check("R10 one cycle", start_o, 0);
    repeat (HOLD) @(negedge clk);
    phase(0,0);
    send_stop();
    settle();
    check("R3 busy cleared", busy_o, 0);
  endtask

  // R6 R7 R8 R9: write frame, address then data byte
  task automatic t_write();
    int b_start = c_start, b_stop = c_stop, b_addr = c_addr, b_ack = c_ack;
    logic [7:0] a = 8'hA4;
    send_start();
    for (int i = 7; i >= 5; i--) send_bit(a[i]);
    settle();
    check("R9 idx after 3 bits", bit_idx_o, 3);
    for (int i = 4; i >= 0; i--) send_bit(a[i]);
    send_bit(1'b0);
    settle();
    check("R9 idx after ack", bit_idx_o, 0);
    check("R7 addr strobe", c_addr - b_addr, 1);
    check("R7 addr value", l_addr, 7'h52);
    check("R7 rw write", l_rw, 0);
    check("R8 ack low", l_ack, 0);
    send_byte(8'h3C, 1'b1);
    settle();
    check("R7 no strobe on data byte", c_addr - b_addr, 1);
    check("R8 ack count", c_ack - b_ack, 2);
    check("R8 nack", l_ack, 1);
    check("R6 no spurious start", c_start - b_start, 1);
    check("R6 no spurious stop", c_stop - b_stop, 0);
    check("R2 busy mid frame", busy_o, 1);
    send_stop();
    settle();
    check("R3 stop count", c_stop - b_stop, 1);
    check("R3 busy free", busy_o, 0);
  endtask

  // R4 R9 R7: repeated START in the middle of a byte
  task automatic t_rstart();
    int b_start = c_start, b_rs = c_rstart, b_addr = c_addr;
    send_start();
    send_byte(8'h90, 1'b0);
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    send_rstart();
    settle();
    check("R4 rstart pulse", c_rstart - b_rs, 1);
    check("R4 no second start", c_start - b_start, 1);
    check("R4 busy held", busy_o, 1);
    check("R9 idx reset on rstart", bit_idx_o, 0);
    send_byte(8'h91, 1'b1);
    settle();
    check("R7 addr after rstart", c_addr - b_addr, 2);
    check("R7 addr value rstart", l_addr, 7'h48);
    check("R7 rw read", l_rw, 1);
    send_stop();
    settle();
    check("R3 busy free after rstart frame", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_arming();
    t_start_latency();
    t_write();
    t_rstart();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule